// File: doc/BRIEF.md
# Match-and-Step Compare Timer

This block holds a free-running 10-bit counter that advances on qualified clock cycles, together with two compare channels. Each channel keeps a compare value and a step size. When a counted cycle finds the counter equal to a channel's compare value, that channel fires. Firing can set, clear or toggle the channel's output pin, can latch a status flag that feeds a shared interrupt line, or can do both.

On every firing the compare value moves forward by the step size, wrapping at 1024. Events therefore repeat at any chosen spacing without software reloading anything.

Software reaches the compare, step and control fields, the status flags and the live count through one word-wide address port. Reading the status word clears it. The tick input comes from an external prescaler.

Top module: `mst_timer`

## Requirements
- R1: The counter is 10 bits wide and increments by one, wrapping from 1023 to 0, only at clock edges where `tick_i` is high. Its value reads back at address 7.
- R2: `event_o[i]` is high in exactly the cycles where `tick_i` is high and the counter equals the compare value of channel i.
- R3: After reset, the following are all zero: the counter, every compare, step and control field, both pins, both status bits, `irq_o` and `event_o`.
- R4: Control bits [1:0] select the pin action applied at the edge that ends a firing cycle: 0 keeps the pin, 1 drives it high, 2 drives it low, and 3 inverts it.
- R5: At the edge that ends a firing cycle, the channel's compare value becomes (compare + step) mod 1024. With a step of 0 the channel fires once per 1024 ticks.
- R6: A write to a channel's compare register takes effect at the next edge, and it overrides the step advance of that same cycle.
- R7: Status bit i is set by a firing of channel i. A read of address 6 returns {ch1, ch0} in bits [1:0] and clears both bits. A firing in the same cycle as the read leaves its bit set.
- R8: `irq_o` is high exactly when some status bit is set and its channel's control bit 2 (interrupt enable) is set.
- R9: The register map is as follows. Channel i has its compare at address 2i and its step at 2i+1. Control for channel 0 is at address 4 and for channel 1 at address 5, with 3 bits readable. Addresses 8 to 15 read as 0. Writes land at the edge where `wr_en_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Count enable for this cycle |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (clears status when address is 6) |
| addr_i | input | 4 | Register address |
| wdata_i | input | 10 | Write data |
| rdata_o | output | 10 | Read data for `addr_i`, combinational |
| event_o | output | 2 | Per-channel firing pulse |
| pin_o | output | 2 | Per-channel output pin |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions assume that inputs are settled and free of X at every rising edge. They also assume that a compare write and a firing of the same channel resolve in a single cycle, with the write taking priority. The stimulus changes inputs only on falling edges and drives only defined values. It deliberately aims compare writes and status reads at the exact cycles where the bench's own model predicts a firing, so that both priority rules are exercised without violating those assumptions.

// File: rtl/mst_pkg.sv
package mst_pkg;
  typedef enum logic [1:0] {
    ACT_HOLD = 2'd0,
    ACT_SET  = 2'd1,
    ACT_CLR  = 2'd2,
    ACT_TGL  = 2'd3
  } pin_act_e;

  typedef struct packed {
    logic     irq_en;
    pin_act_e act;
  } ch_ctrl_t;

  localparam int CTRL_W = $bits(ch_ctrl_t);
endpackage

// File: rtl/mst_counter.sv
module mst_counter #(
  parameter int W = 10
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_o <= '0;
    else if (tick_i) cnt_o <= cnt_o + W'(1);
  end

  a_r1_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(cnt_o));
  a_r1_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> cnt_o == W'($past(cnt_o) + W'(1)));
endmodule

// File: rtl/mst_channel.sv
module mst_channel
  import mst_pkg::*;
#(
  parameter int W = 10
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic [W-1:0] cnt_i,
  input  logic         match_we_i,
  input  logic         step_we_i,
  input  logic         ctrl_we_i,
  input  logic [W-1:0] wdata_i,
  input  logic         clr_i,
  output logic         event_o,
  output logic         pin_o,
  output logic         status_o,
  output logic [W-1:0] match_o,
  output logic [W-1:0] step_o,
  output ch_ctrl_t     ctrl_o
);
  logic hit;
  assign hit     = tick_i && (cnt_i == match_o);
  assign event_o = hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         match_o <= '0;
    else if (match_we_i) match_o <= wdata_i;   // software write beats advance
    else if (hit)        match_o <= match_o + step_o;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        step_o <= '0;
    else if (step_we_i) step_o <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ctrl_o <= '0;
    else if (ctrl_we_i) ctrl_o <= ch_ctrl_t'(wdata_i[CTRL_W-1:0]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pin_o <= 1'b0;
    else if (hit) begin
      unique case (ctrl_o.act)
        ACT_SET:  pin_o <= 1'b1;
        ACT_CLR:  pin_o <= 1'b0;
        ACT_TGL:  pin_o <= ~pin_o;
        default:  pin_o <= pin_o;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_o <= 1'b0;
    else         status_o <= (status_o && !clr_i) || hit;
  end

  a_r5_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (event_o && !match_we_i) |=> match_o == W'($past(match_o) + $past(step_o)));
  a_r6_write_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_we_i |=> match_o == $past(wdata_i));
  a_r4_toggle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (event_o && ctrl_o.act == ACT_TGL) |=> pin_o != $past(pin_o));
  a_r4_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (event_o && ctrl_o.act == ACT_SET) |=> pin_o);
  a_r4_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !event_o |=> $stable(pin_o));
  a_r7_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    event_o |=> status_o);
  a_r7_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !event_o) |=> !status_o);
endmodule

// File: rtl/mst_timer.sv
module mst_timer
  import mst_pkg::*;
#(
  parameter int CNT_W  = 10,
  parameter int NUM_CH = 2,
  parameter int ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  wdata_i,
  output logic [CNT_W-1:0]  rdata_o,
  output logic [NUM_CH-1:0] event_o,
  output logic [NUM_CH-1:0] pin_o,
  output logic              irq_o
);
  localparam int CTRL_BASE = 2 * NUM_CH;
  localparam int STAT_ADDR = 3 * NUM_CH;
  localparam int CNT_ADDR  = 3 * NUM_CH + 1;

  logic [CNT_W-1:0]  cnt;
  logic [NUM_CH-1:0] status;
  logic [NUM_CH-1:0] irq_en;
  logic [CNT_W-1:0]  match_v [NUM_CH];
  logic [CNT_W-1:0]  step_v  [NUM_CH];
  ch_ctrl_t          ctrl_v  [NUM_CH];
  logic              stat_rd;

  assign stat_rd = rd_en_i && (addr_i == ADDR_W'(STAT_ADDR));

  mst_counter #(.W(CNT_W)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_i(tick_i),
    .cnt_o (cnt)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic mwe, swe, cwe;
    assign mwe = wr_en_i && (addr_i == ADDR_W'(2 * i));
    assign swe = wr_en_i && (addr_i == ADDR_W'(2 * i + 1));
    assign cwe = wr_en_i && (addr_i == ADDR_W'(CTRL_BASE + i));
    assign irq_en[i] = ctrl_v[i].irq_en;

    mst_channel #(.W(CNT_W)) u_ch (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .tick_i    (tick_i),
      .cnt_i     (cnt),
      .match_we_i(mwe),
      .step_we_i (swe),
      .ctrl_we_i (cwe),
      .wdata_i   (wdata_i),
      .clr_i     (stat_rd),
      .event_o   (event_o[i]),
      .pin_o     (pin_o[i]),
      .status_o  (status[i]),
      .match_o   (match_v[i]),
      .step_o    (step_v[i]),
      .ctrl_o    (ctrl_v[i])
    );
  end

  assign irq_o = |(status & irq_en);

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (addr_i == ADDR_W'(2 * i))         rdata_o = match_v[i];
      if (addr_i == ADDR_W'(2 * i + 1))     rdata_o = step_v[i];
      if (addr_i == ADDR_W'(CTRL_BASE + i)) rdata_o = CNT_W'(ctrl_v[i]);
    end
    if (addr_i == ADDR_W'(STAT_ADDR)) rdata_o = CNT_W'(status);
    if (addr_i == ADDR_W'(CNT_ADDR))  rdata_o = cnt;
  end

  a_r8_quiet_after_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_rd && event_o == '0) |=> !irq_o);
  a_r8_irq_needs_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> status != '0);
endmodule

// File: tb/tb_mst_timer.sv
`timescale 1ns/1ps
module tb_mst_timer;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0, wr_en_i = 1'b0, rd_en_i = 1'b0;
  logic [3:0] addr_i = '0;
  logic [9:0] wdata_i = '0;
  logic [9:0] rdata_o;
  logic [1:0] event_o, pin_o;
  logic       irq_o;

  always #5 clk_i = ~clk_i;

  mst_timer dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .wr_en_i(wr_en_i),
    .rd_en_i(rd_en_i), .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .event_o(event_o), .pin_o(pin_o), .irq_o(irq_o)
  );

  int checks = 0, errors = 0;
  bit done = 0;
  int mcnt;
  int mm[2], ms[2], ma[2], mi[2], mp[2], mst[2];

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic int exp_rd(input int a);
    if (a < 4) return (a % 2 == 0) ? mm[a / 2] : ms[a / 2];
    if (a == 4 || a == 5) return ma[a - 4] + 4 * mi[a - 4];
    if (a == 6) return mst[0] + 2 * mst[1];
    if (a == 7) return mcnt;
    return 0;
  endfunction

  task automatic model_reset();
    mcnt = 0;
    for (int i = 0; i < 2; i++) begin
      mm[i] = 0; ms[i] = 0; ma[i] = 0; mi[i] = 0; mp[i] = 0; mst[i] = 0;
    end
  endtask

  // one clock: drive, compare against model, then advance the model
  task automatic cyc(input bit tk, input bit we, input bit re, input int a, input int d);
    int ev[2];
    string rtag;
    @(negedge clk_i);
    tick_i = tk; wr_en_i = we; rd_en_i = re; addr_i = a[3:0]; wdata_i = d[9:0];
    #1;
    for (int i = 0; i < 2; i++) ev[i] = (tk && mcnt == mm[i]) ? 1 : 0;
    chk("R2 event", int'(event_o), ev[0] + 2 * ev[1]);
    chk("R4 pin", int'(pin_o), mp[0] + 2 * mp[1]);
    chk("R8 irq", int'(irq_o), ((mst[0] & mi[0]) | (mst[1] & mi[1])));
    rtag = (a == 7) ? "R1 count" : (a == 6) ? "R7 status" : "R9 readback";
    chk(rtag, int'(rdata_o), exp_rd(a));
    @(posedge clk_i);
    for (int i = 0; i < 2; i++) begin
      if (re && a == 6) mst[i] = 0;
      if (ev[i] != 0) begin
        mst[i] = 1;
        if (ma[i] == 1) mp[i] = 1;
        else if (ma[i] == 2) mp[i] = 0;
        else if (ma[i] == 3) mp[i] = 1 - mp[i];
        mm[i] = (mm[i] + ms[i]) % 1024;   // R5
      end
      if (we && a == 2 * i) mm[i] = d % 1024;   // R6 override
      if (we && a == 2 * i + 1) ms[i] = d % 1024;
      if (we && a == 4 + i) begin ma[i] = d % 4; mi[i] = (d / 4) % 2; end
    end
    if (tk) mcnt = (mcnt + 1) % 1024;
  endtask

  task automatic wr(input int a, input int d); cyc(0, 1, 0, a, d); endtask

  initial begin
    #2000000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk_i);
    #1;
    chk("R3 reset pins", int'(pin_o), 0);
    chk("R3 reset irq", int'(irq_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    for (int a = 0; a < 8; a++) cyc(0, 0, 0, a, 0);   // R3 all fields zero

    // R9/R4/R8 setup: ch0 set+irq, ch1 toggle no irq, step 0 on ch1
    wr(0, 5); wr(1, 7); wr(4, 1 + 4);
    wr(2, 3); wr(3, 0); wr(5, 3);
    for (int k = 0; k < 60; k++) cyc((k % 3) != 0, 0, 0, k % 8, 0);
    cyc(0, 0, 1, 6, 0);                                // R7 clear
    for (int k = 0; k < 20; k++) cyc(1, 0, 0, 7, 0);

    // drive-low action, large step to wrap the sum (R5)
    wr(4, 2 + 4); wr(1, 1000);
    for (int k = 0; k < 1100; k++) cyc(1, 0, 0, (k % 2) ? 0 : 7, 0);

    // R6: compare write in the firing cycle
    while (mcnt != mm[0]) cyc(1, 0, 0, 7, 0);
    cyc(1, 1, 0, 0, 100);
    cyc(0, 0, 0, 0, 0);

    // R7: status read coinciding with a firing; ch1 irq on (R8)
    wr(5, 3 + 4);
    cyc(0, 0, 1, 6, 0);
    while (mcnt != mm[1]) cyc(1, 0, 0, 6, 0);
    cyc(1, 0, 1, 6, 0);
    cyc(0, 0, 0, 6, 0);
    cyc(0, 0, 1, 6, 0);
    cyc(0, 0, 0, 6, 0);

    // R9 unmapped addresses
    for (int a = 8; a < 16; a++) cyc(0, 0, 0, a, 0);
    for (int a = 8; a < 16; a++) wr(a, 1023);
    for (int a = 0; a < 8; a++) cyc(1, 0, 0, a, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule